// File: doc/BRIEF.md
# Infrared Transceiver Power-Mode Sequencer

This block sits on the host side of a serial infrared transceiver and owns the two logic pins that reach it: the shutdown/mode line and the transmit-data line. When no command is running it forwards the host's transmit bit to the data pin and holds the mode line low, so the transceiver is active.

The host can issue four commands:

- Put the transceiver into shutdown.
- Wake it from shutdown.
- Select high transmit power.
- Select low transmit power.

A power selection works by pulsing the mode line high. The level of the data line at the moment the mode line falls decides the power mode. The sequencer places that falling edge inside a setup and hold window, built from clock cycles that are computed from the clock period parameter.

While a selection is running, the sequencer raises `busy`, blocks the host's transmit bit and drops any new command. A one-cycle `done` marks the end of every accepted command. A mode register keeps the last power mode that was programmed and can be read on `mode_low`.

Top module: `ir_mode_seq`

## Requirements
- R1: After a synchronous reset, `sd_out` is 0, `busy` is 0, `done` is 0 and `mode_low` is 0 (0 means high power, 1 means low power).
- R2: While idle, `txd_out` follows `user_txd` in the same cycle (combinational path) and `sd_out` is 0.
- R3: Command code 0 (shutdown) accepted at an edge drives `sd_out`=1 and `txd_out`=0 from that edge onward. It pulses `done` for one cycle and keeps `user_txd` blocked for as long as shutdown lasts.
- R4: Command code 1 (wake) takes the sequencer from shutdown back to idle at the accepting edge and pulses `done`. When it is accepted while already idle, it changes nothing except the `done` pulse.
- R5: Command code 3 (low power) holds `sd_out`=1 with `txd_out`=0 for LEAD = floor(25/P)+1 cycles, where P is CLK_PERIOD_NS. It then holds `sd_out`=1 with `txd_out`=1 for SU = max(ceil(25/P), PULSE−LEAD) cycles.
- R6: Command code 2 (high power) follows the same timing as R5, but `txd_out` stays 0 for the whole sequence.
- R7: After `sd_out` falls, `txd_out` keeps the selected level for HOLD = ceil(100/P) cycles while `busy` stays 1.
- R8: During a power selection, `sd_out` stays high for at least PULSE = floor(50/P)+1 consecutive cycles before it falls.
- R9: `mode_low` takes the selected mode in the first cycle with `sd_out` low after the pulse, and changes at no other time.
- R10: While `busy` is 1, commands are ignored, `user_txd` does not reach `txd_out`, and an ignored shutdown does not leave `sd_out` high afterwards.
- R11: `done` is 1 for exactly the one cycle after the hold ends. A command presented during that cycle is accepted at the following edge.
- R12: A power selection started from shutdown ends with the transceiver active (`sd_out`=0) and transmit pass-through restored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command strobe, sampled at each rising edge |
| req_op | input | 2 | Command code: 0 shutdown, 1 wake, 2 high power, 3 low power |
| user_txd | input | 1 | Host transmit bit |
| sd_out | output | 1 | Shutdown/mode pin to the transceiver |
| txd_out | output | 1 | Transmit-data pin to the transceiver |
| busy | output | 1 | A power selection is in progress |
| done | output | 1 | One-cycle completion pulse |
| mode_low | output | 1 | Last programmed mode, 1 = low power |

## Verification
Two things can coincide here: the end of a power selection, signalled by `done` and the return to idle, and the arrival of the next command. The bench provokes this in two ways. It presents a command during the last hold cycle, which must be dropped, and it presents a command in the `done` cycle, which must start its lead phase at the very next edge. The scoreboard judges both cases by comparing pin levels against a queue of expected per-cycle values with no gap between the two sequences. It also injects a shutdown command in the middle of a sequence, while `user_txd` is held high, and checks that neither the pins nor the final state show any trace of it.

// File: rtl/irpm_pkg.sv
package irpm_pkg;

    typedef enum logic [1:0] {
        OP_SLEEP  = 2'd0,
        OP_WAKE   = 2'd1,
        OP_PWR_HI = 2'd2,
        OP_PWR_LO = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLEEP,
        ST_LEAD,
        ST_SETUP,
        ST_HOLD
    } st_e;

    typedef struct packed {
        logic sd;
        logic txd;
        logic pass;
    } pin_ctl_t;

    // cycles covering at least ns nanoseconds, never fewer than one
    function automatic int cyc_atleast(int ns, int per);
        int c;
        c = (ns + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    // cycles covering strictly more than ns nanoseconds
    function automatic int cyc_over(int ns, int per);
        return ns / per + 1;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/irpm_timer.sv
module irpm_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/irpm_ctrl.sv
module irpm_ctrl
    import irpm_pkg::*;
#(
    parameter int N_LEAD  = 3,
    parameter int N_SETUP = 3,
    parameter int N_HOLD  = 10,
    parameter int W       = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic [1:0]   req_op,
    input  logic         expired,
    output logic         load,
    output logic [W-1:0] load_val,
    output st_e          st,
    output logic         target,
    output logic         mode_q,
    output logic         done_q,
    output logic         busy
);
    localparam logic [W-1:0] LV_LEAD  = W'(N_LEAD - 1);
    localparam logic [W-1:0] LV_SETUP = W'(N_SETUP - 1);
    localparam logic [W-1:0] LV_HOLD  = W'(N_HOLD - 1);

    st_e  nxt;
    logic accept;
    logic is_prog;
    logic finish;

    assign busy    = (st == ST_LEAD) || (st == ST_SETUP) || (st == ST_HOLD);
    assign accept  = req_valid && !busy;
    assign is_prog = req_op[1];
    assign finish  = (st == ST_HOLD) && expired;

    always_comb begin
        nxt      = st;
        load     = 1'b0;
        load_val = '0;
        unique case (st)
            ST_IDLE, ST_SLEEP: begin
                if (accept) begin
                    unique case (op_e'(req_op))
                        OP_SLEEP: nxt = ST_SLEEP;
                        OP_WAKE:  nxt = ST_IDLE;
                        default: begin
                            nxt      = ST_LEAD;
                            load     = 1'b1;
                            load_val = LV_LEAD;
                        end
                    endcase
                end
            end
            ST_LEAD: begin
                if (expired) begin
                    nxt      = ST_SETUP;
                    load     = 1'b1;
                    load_val = LV_SETUP;
                end
            end
            ST_SETUP: begin
                if (expired) begin
                    nxt      = ST_HOLD;
                    load     = 1'b1;
                    load_val = LV_HOLD;
                end
            end
            ST_HOLD: begin
                if (expired)
                    nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            target <= 1'b0;
            mode_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            st     <= nxt;
            done_q <= (accept && !is_prog) || finish;
            if (accept && is_prog)
                target <= req_op[0];
            if ((st == ST_SETUP) && expired)
                mode_q <= target;
        end
    end
endmodule

// File: rtl/irpm_pinmux.sv
module irpm_pinmux
    import irpm_pkg::*;
(
    input  st_e  st,
    input  logic target,
    input  logic user_txd,
    output logic sd_out,
    output logic txd_out
);
    pin_ctl_t ctl;

    always_comb begin
        unique case (st)
            ST_IDLE:  ctl = '{sd: 1'b0, txd: 1'b0,   pass: 1'b1};
            ST_SLEEP: ctl = '{sd: 1'b1, txd: 1'b0,   pass: 1'b0};
            ST_LEAD:  ctl = '{sd: 1'b1, txd: 1'b0,   pass: 1'b0};
            ST_SETUP: ctl = '{sd: 1'b1, txd: target, pass: 1'b0};
            ST_HOLD:  ctl = '{sd: 1'b0, txd: target, pass: 1'b0};
            default:  ctl = '{sd: 1'b0, txd: 1'b0,   pass: 1'b0};
        endcase
    end

    assign sd_out  = ctl.sd;
    assign txd_out = ctl.pass ? user_txd : ctl.txd;
endmodule

// File: rtl/ir_mode_seq.sv
module ir_mode_seq
    import irpm_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int LEAD_NS       = 25,
    parameter int SETUP_NS      = 25,
    parameter int PULSE_NS      = 50,
    parameter int HOLD_NS       = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic       user_txd,
    output logic       sd_out,
    output logic       txd_out,
    output logic       busy,
    output logic       done,
    output logic       mode_low
);
    localparam int N_LEAD  = cyc_over(LEAD_NS, CLK_PERIOD_NS);
    localparam int N_PULSE = cyc_over(PULSE_NS, CLK_PERIOD_NS);
    localparam int N_SETUP = imax(cyc_atleast(SETUP_NS, CLK_PERIOD_NS),
                                  imax(N_PULSE - N_LEAD, 1));
    localparam int N_HOLD  = cyc_atleast(HOLD_NS, CLK_PERIOD_NS);
    localparam int N_MAX   = imax(N_LEAD, imax(N_SETUP, N_HOLD));
    localparam int W       = imax($clog2(N_MAX + 1), 1);

    logic         load;
    logic [W-1:0] load_val;
    logic         expired;
    st_e          st;
    logic         target;

    irpm_timer #(.W(W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    irpm_ctrl #(
        .N_LEAD  (N_LEAD),
        .N_SETUP (N_SETUP),
        .N_HOLD  (N_HOLD),
        .W       (W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .expired   (expired),
        .load      (load),
        .load_val  (load_val),
        .st        (st),
        .target    (target),
        .mode_q    (mode_low),
        .done_q    (done),
        .busy      (busy)
    );

    irpm_pinmux u_pins (
        .st       (st),
        .target   (target),
        .user_txd (user_txd),
        .sd_out   (sd_out),
        .txd_out  (txd_out)
    );
endmodule

// File: rtl/irpm_checker.sv
module irpm_checker
    import irpm_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int PULSE_NS      = 50
) (
    input logic clk,
    input logic rst,
    input logic sd_out,
    input logic txd_out,
    input logic busy,
    input logic done,
    input logic mode_low
);
    localparam int N_PULSE = cyc_over(PULSE_NS, CLK_PERIOD_NS);

    int hi_cnt;
    always_ff @(posedge clk) begin
        if (rst)
            hi_cnt <= 0;
        else if (sd_out)
            hi_cnt <= (hi_cnt < 1000000) ? hi_cnt + 1 : hi_cnt;
        else
            hi_cnt <= 0;
    end

    // R8: a mode pulse lasts long enough before it falls
    p_pulse_width_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(sd_out) && busy) |-> (hi_cnt >= N_PULSE));

    // R7: the data pin is frozen while the hold after the falling edge lasts
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !sd_out && $past(busy) && !$past(sd_out)) |-> $stable(txd_out));

    // R9: the mode register changes only right after the mode pin falls
    p_mode_at_fall_r9: assert property (@(posedge clk) disable iff (rst)
        (mode_low != $past(mode_low)) |-> ($past(sd_out) && !sd_out && busy));

    // R3: no data is driven while in shutdown
    p_shut_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (sd_out && !busy) |-> !txd_out);

    // R5: the data pin rises only after the mode pin was already high
    p_setup_order_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(txd_out) && busy) |-> (sd_out && $past(sd_out)));

    // R11: completion is never flagged during a running sequence
    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind ir_mode_seq irpm_checker #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .PULSE_NS      (PULSE_NS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sd_out   (sd_out),
    .txd_out  (txd_out),
    .busy     (busy),
    .done     (done),
    .mode_low (mode_low)
);

// File: tb/sim_ir_mode_seq.sv
module sim_ir_mode_seq;
    localparam int PER = 10;

    // expected timing from the requirements, computed here
    localparam int E_LEAD  = 25 / PER + 1;
    localparam int E_PULSE = 50 / PER + 1;
    localparam int E_SU0   = (25 + PER - 1) / PER;
    localparam int E_SU    = (E_SU0 > E_PULSE - E_LEAD) ? E_SU0 : E_PULSE - E_LEAD;
    localparam int E_HOLD  = (100 + PER - 1) / PER;
    localparam int E_BUSY  = E_LEAD + E_SU + E_HOLD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic user_txd = 1'b0;
    logic sd_out, txd_out, busy, done, mode_low;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit exp_mode = 1'b0;

    // expected item: {sd, txd, busy, done, mode}
    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #(PER / 2) clk = ~clk;

    ir_mode_seq #(.CLK_PERIOD_NS(PER)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .user_txd(user_txd), .sd_out(sd_out), .txd_out(txd_out),
        .busy(busy), .done(done), .mode_low(mode_low)
    );

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got sd/txd/busy/done/mode=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push(input string tag, input logic [4:0] item, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(item);
            tag_q.push_back(tag);
        end
    endtask

    // monitor: compares one expected item per cycle, in the middle of the cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [4:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {sd_out, txd_out, busy, done, mode_low}, e);
        end
    end

    // power selection: called just after a rising edge, returns 1 ns into the done cycle
    task automatic prog(input bit lo, input string tag, input bit inject);
        bit old_m;
        old_m = exp_mode;
        req_valid = 1'b1;
        req_op = lo ? 2'd3 : 2'd2;
        @(posedge clk); #1;
        req_valid = 1'b0;
        push(tag, {1'b1, 1'b0, 1'b1, 1'b0, old_m}, E_LEAD);
        push(tag, {1'b1, lo,   1'b1, 1'b0, old_m}, E_SU);
        push("R7", {1'b0, lo,  1'b1, 1'b0, lo}, E_HOLD);
        push("R11", {1'b0, user_txd, 1'b0, 1'b1, lo}, 1);
        exp_mode = lo;
        for (int i = 1; i <= E_BUSY; i++) begin
            @(posedge clk); #1;
            if (inject && i == 4) begin
                req_valid = 1'b1;
                req_op = 2'd0;
            end else if (inject && i == 5) begin
                req_valid = 1'b0;
            end else if (inject && i == E_BUSY - 1) begin
                req_valid = 1'b1;  // present during the last hold cycle: dropped
                req_op = 2'd0;
            end else if (inject && i == E_BUSY) begin
                req_valid = 1'b0;
            end
        end
    endtask

    // single-edge command: called just after a rising edge, returns 1 ns into the done cycle
    task automatic simple(input bit sleep, input string tag);
        req_valid = 1'b1;
        req_op = sleep ? 2'd0 : 2'd1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        push(tag, {sleep, sleep ? 1'b0 : user_txd, 1'b0, 1'b1, exp_mode}, 1);
    endtask

    task automatic settle();
        wait (exp_q.size() == 0);
        @(posedge clk); #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(PER * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #3;
        check("R1", {sd_out, txd_out, busy, done, mode_low}, 5'b00000);

        // R2 pass-through in idle, same cycle
        user_txd = 1'b1; #1;
        check("R2", {sd_out, txd_out, 3'b000}, {2'b01, 3'b000});
        user_txd = 1'b0; #1;
        check("R2", {sd_out, txd_out, 3'b000}, {2'b00, 3'b000});
        @(posedge clk); #1;

        // R5 low power, host bit high must stay blocked (R10)
        user_txd = 1'b1;
        prog(1'b1, "R5", 1'b0);
        settle();
        check("R9", {4'b0000, mode_low}, {4'b0000, 1'b1});
        user_txd = 1'b0; #1;
        check("R2", {sd_out, txd_out, 3'b000}, 5'b00000);
        @(posedge clk); #1;

        // R6 high power with host bit high
        user_txd = 1'b1;
        prog(1'b0, "R6", 1'b0);
        settle();

        // R10 commands while busy are dropped (R8 pulse length covered in trace)
        prog(1'b1, "R10", 1'b1);
        settle();
        check("R10", {sd_out, 1'b0, busy, 1'b0, mode_low}, {1'b0, 1'b0, 1'b0, 1'b0, 1'b1});

        // R11 back to back: second command presented in the done cycle
        prog(1'b0, "R8", 1'b0);
        prog(1'b1, "R11", 1'b0);
        settle();

        // R3 shutdown, host bit blocked
        user_txd = 1'b1;
        simple(1'b1, "R3");
        settle();
        check("R3", {sd_out, txd_out, busy, done, 1'b0}, {1'b1, 1'b0, 1'b0, 1'b0, 1'b0});

        // R12 selection from shutdown ends active
        prog(1'b0, "R12", 1'b0);
        settle();
        check("R12", {sd_out, txd_out, busy, 1'b0, mode_low}, {1'b0, 1'b1, 1'b0, 1'b0, 1'b0});

        // R4 wake from shutdown, then wake while idle
        simple(1'b1, "R3");
        simple(1'b0, "R4");
        settle();
        simple(1'b0, "R4");
        settle();
        user_txd = 1'b0; #1;
        check("R4", {sd_out, txd_out, busy, done, mode_low}, 5'b00000);

        repeat (2) @(posedge clk);
        summary();
    end
endmodule